// File: doc/BRIEF.md
# External Interrupt Request Dispatcher

This block gathers a set of external interrupt sources into a sticky request register. It masks them with a per-source enable vector and a global enable bit. While any source that is both latched and enabled is waiting, it raises one shared external-interrupt request toward the core. A high-priority machine-check input overrides that path and cannot be masked. The core-facing vector number tells the two causes apart.

When the interrupt path asks which source to serve, it pulses a select strobe. The block then walks a programmable order table from its first entry. Each entry names a source number, and only the first `count` entries are looked at. The first entry whose source is latched and enabled wins, and the block reports an extended vector equal to the base (32) plus that source number. If the winning source has no handler marked valid, the result is flagged as spurious. If some source is waiting but no entry in range names it, the result is also spurious, and no vector is given. Requests stay latched until a write-one-to-clear strobe removes them.

Top module: `exirq_dispatch`

## Requirements
- R1: A source line that is high at a clock edge sets its request bit. The bit stays set after the line falls, until a clear strobe carries a 1 in that bit position. If the line is still high at the clear edge, the bit remains set.
- R2: `ext_irq_o` is 1 exactly when the global enable is 1 and some request bit is set whose `src_en_i` bit is also 1. It reflects a new request from the cycle after the request is latched.
- R3: While `glob_en_i` is 0, `ext_irq_o` is 0, and a strobe reports no hit and no spurious flag.
- R4: `core_req_o` is 1 when `hpmc_i` is 1 or `ext_irq_o` is 1. `core_vec_o` is 1 when `hpmc_i` is 1, whatever the global enable is. Otherwise it is 4 when `ext_irq_o` is 1, and 0 when no request is raised.
- R5: One cycle after `sel_stb_i`, `sel_done_o` is 1 for one cycle. At that point `sel_hit_o` is 1 and `sel_vec_o` equals 32 + k, where k is the source named by the lowest-indexed table entry (index < count) whose source is latched and enabled.
- R6: Table entry i is written with source number `tbl_wdata_i` at address `tbl_addr_i = i`. The count is written through `cnt_wdata_i`, and a value above 32 acts as 32. Entries at index ≥ count are never chosen.
- R7: If the chosen source's `hdl_vld_i` bit is 0, `spur_o` is 1 and `sel_hit_o` is 1, with the vector as in R5. If a source is eligible but no in-range entry names it, `spur_o` is 1, `sel_hit_o` is 0 and `sel_vec_o` is 0.
- R8: A strobe with no eligible source gives `sel_hit_o` = 0, `spur_o` = 0 and `sel_vec_o` = 0.
- R9: After reset, every request bit is clear, table entry i holds source i, the count is 32 and every output is 0.
- R10: `sel_hit_o`, `spur_o` and `sel_vec_o` hold their value between strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_req_i | input | 32 | Level request line per source |
| clr_we_i | input | 1 | Clear strobe for request bits |
| clr_mask_i | input | 32 | Write-one-to-clear mask |
| glob_en_i | input | 1 | Global external enable |
| src_en_i | input | 32 | Per-source enable |
| hdl_vld_i | input | 32 | Per-source handler-present mask |
| hpmc_i | input | 1 | Unmaskable machine check |
| tbl_we_i | input | 1 | Order table write strobe |
| tbl_addr_i | input | 5 | Order table entry index |
| tbl_wdata_i | input | 5 | Source number to store |
| cnt_we_i | input | 1 | Count write strobe |
| cnt_wdata_i | input | 6 | Number of entries to scan |
| sel_stb_i | input | 1 | Start a selection |
| ext_irq_o | output | 1 | Shared external request |
| core_req_o | output | 1 | Any request toward the core |
| core_vec_o | output | 5 | Core vector: 1 machine check, 4 external |
| sel_done_o | output | 1 | Selection result valid pulse |
| sel_hit_o | output | 1 | A table entry matched |
| spur_o | output | 1 | Spurious indication |
| sel_vec_o | output | 6 | Extended vector 32..63 |

## Verification
Every single source is raised on its own under the identity order, so a wrong vector offset or bit index shows up for that source alone. Pairs of sources that do not follow a fixed pattern are then scanned under a reversed order, under a shortened count and under a patchy handler mask. These patterns separate a scan that follows table order from a plain fixed-priority encoder, and they show whether the count limit and the spurious rule each take effect. Separate patterns cover the clear racing a source that is still high, a disabled source, the global enable being off, and the machine check overriding a masked state.

// File: rtl/exirq_pkg.sv
// Package: shared constants and result type for the external interrupt dispatcher.
// Assumes a 5-bit core vector space.
package exirq_pkg;
    localparam int CORE_VW          = 5;
    localparam logic [CORE_VW-1:0] EXT_VEC  = 5'd4;
    localparam logic [CORE_VW-1:0] HPMC_VEC = 5'd1;

    // Result of one selection strobe.
    typedef struct packed {
        logic       hit;
        logic       spur;
        logic [5:0] vec;
    } sel_res_t;
endpackage

// File: rtl/exirq_pend.sv
// Module: sticky request register. A set from a high source line wins over
// a write-one-to-clear in the same cycle. Assumes synchronous sources.
module exirq_pend #(
    parameter int NSRC = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src_req_i,
    input  logic            clr_we_i,
    input  logic [NSRC-1:0] clr_mask_i,
    output logic [NSRC-1:0] pend_o
);
    logic [NSRC-1:0] pend_q;
    logic [NSRC-1:0] clr_bits;

    // Select the bits to clear this cycle.
    always_comb begin
        clr_bits = clr_we_i ? clr_mask_i : '0;
    end

    // Hold, clear or set each request bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else begin
            pend_q <= (pend_q & ~clr_bits) | src_req_i;
        end
    end

    assign pend_o = pend_q;
endmodule

// File: rtl/exirq_order_tbl.sv
// Module: programmable check-order table plus valid-entry count. Resets to
// the identity order with all entries in use. Count writes above DEPTH are
// clamped to DEPTH.
module exirq_order_tbl #(
    parameter int DEPTH = 32,
    parameter int IDXW  = 5,
    parameter int TAW   = $clog2(DEPTH),
    parameter int CNTW  = $clog2(DEPTH + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  tbl_we_i,
    input  logic [TAW-1:0]        tbl_addr_i,
    input  logic [IDXW-1:0]       tbl_wdata_i,
    input  logic                  cnt_we_i,
    input  logic [CNTW-1:0]       cnt_wdata_i,
    output logic [DEPTH*IDXW-1:0] tbl_flat_o,
    output logic [CNTW-1:0]       cnt_o
);
    logic [IDXW-1:0] ent_q [DEPTH];
    logic [CNTW-1:0] cnt_q;

    // Store one entry per generate slot.
    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ent_q[g] <= IDXW'(g);
            end else if (tbl_we_i && (tbl_addr_i == TAW'(g))) begin
                ent_q[g] <= tbl_wdata_i;
            end
        end
        assign tbl_flat_o[g*IDXW +: IDXW] = ent_q[g];
    end

    // Keep the number of entries to scan, clamped to the table depth.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= CNTW'(DEPTH);
        end else if (cnt_we_i) begin
            cnt_q <= (cnt_wdata_i > CNTW'(DEPTH)) ? CNTW'(DEPTH) : cnt_wdata_i;
        end
    end

    assign cnt_o = cnt_q;
endmodule

// File: rtl/exirq_scan.sv
// Module: combinational scan of the order table. Finds the lowest-index
// entry below the count whose source is eligible. Assumes NSRC = 2**IDXW.
module exirq_scan #(
    parameter int NSRC  = 32,
    parameter int DEPTH = 32,
    parameter int IDXW  = 5,
    parameter int TAW   = $clog2(DEPTH),
    parameter int CNTW  = $clog2(DEPTH + 1)
) (
    input  logic [NSRC-1:0]       elig_i,
    input  logic [DEPTH*IDXW-1:0] tbl_flat_i,
    input  logic [CNTW-1:0]       cnt_i,
    output logic                  hit_o,
    output logic [IDXW-1:0]       src_o
);
    logic [DEPTH-1:0] match;
    logic [IDXW-1:0]  ent [DEPTH];
    logic [TAW-1:0]   win;

    // Per-entry test: in range and naming an eligible source.
    for (genvar g = 0; g < DEPTH; g++) begin : g_match
        assign ent[g]   = tbl_flat_i[g*IDXW +: IDXW];
        assign match[g] = (CNTW'(g) < cnt_i) && elig_i[ent[g]];
    end

    // Priority pick: the lowest matching index wins.
    always_comb begin
        hit_o = 1'b0;
        win   = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (match[i]) begin
                hit_o = 1'b1;
                win   = TAW'(i);
            end
        end
    end

    assign src_o = ent[win];
endmodule

// File: rtl/exirq_dispatch.sv
// Module: top of the external interrupt dispatcher. Latches requests, masks
// them, raises the shared request and, on a strobe, registers the selected
// extended vector with its spurious flag. Assumes NSRC = 2**$clog2(NSRC).
module exirq_dispatch
    import exirq_pkg::*;
#(
    parameter int NSRC     = 32,
    parameter int DEPTH    = 32,
    parameter int VEC_BASE = 32,
    parameter int IDXW     = $clog2(NSRC),
    parameter int TAW      = $clog2(DEPTH),
    parameter int CNTW     = $clog2(DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NSRC-1:0]    src_req_i,
    input  logic               clr_we_i,
    input  logic [NSRC-1:0]    clr_mask_i,
    input  logic               glob_en_i,
    input  logic [NSRC-1:0]    src_en_i,
    input  logic [NSRC-1:0]    hdl_vld_i,
    input  logic               hpmc_i,
    input  logic               tbl_we_i,
    input  logic [TAW-1:0]     tbl_addr_i,
    input  logic [IDXW-1:0]    tbl_wdata_i,
    input  logic               cnt_we_i,
    input  logic [CNTW-1:0]    cnt_wdata_i,
    input  logic               sel_stb_i,
    output logic               ext_irq_o,
    output logic               core_req_o,
    output logic [CORE_VW-1:0] core_vec_o,
    output logic               sel_done_o,
    output logic               sel_hit_o,
    output logic               spur_o,
    output logic [5:0]         sel_vec_o
);
    logic [NSRC-1:0]       pend;
    logic [NSRC-1:0]       elig;
    logic [DEPTH*IDXW-1:0] tbl_flat;
    logic [CNTW-1:0]       cnt;
    logic                  scan_hit;
    logic [IDXW-1:0]       scan_src;
    sel_res_t              res_d;
    sel_res_t              res_q;
    logic                  done_q;

    exirq_pend #(.NSRC(NSRC)) i_pend (
        .clk        (clk),
        .rst_n      (rst_n),
        .src_req_i  (src_req_i),
        .clr_we_i   (clr_we_i),
        .clr_mask_i (clr_mask_i),
        .pend_o     (pend)
    );

    exirq_order_tbl #(.DEPTH(DEPTH), .IDXW(IDXW), .TAW(TAW), .CNTW(CNTW)) i_tbl (
        .clk         (clk),
        .rst_n       (rst_n),
        .tbl_we_i    (tbl_we_i),
        .tbl_addr_i  (tbl_addr_i),
        .tbl_wdata_i (tbl_wdata_i),
        .cnt_we_i    (cnt_we_i),
        .cnt_wdata_i (cnt_wdata_i),
        .tbl_flat_o  (tbl_flat),
        .cnt_o       (cnt)
    );

    // Eligible sources: latched, enabled, and globally allowed.
    always_comb begin
        elig = pend & src_en_i & {NSRC{glob_en_i}};
    end

    exirq_scan #(.NSRC(NSRC), .DEPTH(DEPTH), .IDXW(IDXW), .TAW(TAW), .CNTW(CNTW)) i_scan (
        .elig_i     (elig),
        .tbl_flat_i (tbl_flat),
        .cnt_i      (cnt),
        .hit_o      (scan_hit),
        .src_o      (scan_src)
    );

    // Shared request and core-facing vector; the machine check takes precedence.
    always_comb begin
        ext_irq_o  = |elig;
        core_req_o = hpmc_i | ext_irq_o;
        if (hpmc_i) begin
            core_vec_o = HPMC_VEC;
        end else if (ext_irq_o) begin
            core_vec_o = EXT_VEC;
        end else begin
            core_vec_o = '0;
        end
    end

    // Form the next selection result from the scan outcome.
    always_comb begin
        res_d = '0;
        if (|elig) begin
            if (scan_hit) begin
                res_d.hit  = 1'b1;
                res_d.spur = ~hdl_vld_i[scan_src];
                res_d.vec  = 6'(VEC_BASE) + 6'(scan_src);
            end else begin
                res_d.spur = 1'b1;
            end
        end
    end

    // Register the result on a strobe and pulse done one cycle later.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= sel_stb_i;
            if (sel_stb_i) begin
                res_q <= res_d;
            end
        end
    end

    assign sel_done_o = done_q;
    assign sel_hit_o  = res_q.hit;
    assign spur_o     = res_q.spur;
    assign sel_vec_o  = res_q.vec;
endmodule

// File: rtl/exirq_dispatch_chk.sv
// Module: property checker for the dispatcher, attached by bind. Observes
// ports only.
module exirq_dispatch_chk #(
    parameter int NSRC = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic [NSRC-1:0] src_req_i,
    input logic            clr_we_i,
    input logic [NSRC-1:0] clr_mask_i,
    input logic            glob_en_i,
    input logic            hpmc_i,
    input logic            sel_stb_i,
    input logic            ext_irq_o,
    input logic            core_req_o,
    input logic [4:0]      core_vec_o,
    input logic            sel_done_o,
    input logic            sel_hit_o,
    input logic            spur_o,
    input logic [5:0]      sel_vec_o
);
    p_clear_all_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we_i && (&clr_mask_i) && (src_req_i == '0)) |=> !ext_irq_o);

    p_glob_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !glob_en_i |-> !ext_irq_o);

    p_hpmc_vec_r4: assert property (@(posedge clk) disable iff (!rst_n)
        hpmc_i |-> (core_req_o && core_vec_o == 5'd1));

    p_ext_vec_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_irq_o && !hpmc_i) |-> (core_vec_o == 5'd4));

    p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        sel_stb_i |=> sel_done_o);

    p_no_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_stb_i |=> !sel_done_o);

    p_vec_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        sel_hit_o |-> (sel_vec_o >= 6'd32));

    p_miss_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_hit_o |-> (sel_vec_o == 6'd0));

    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_stb_i |=> ($stable(sel_vec_o) && $stable(spur_o) && $stable(sel_hit_o)));
endmodule

bind exirq_dispatch exirq_dispatch_chk #(.NSRC(NSRC)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .src_req_i  (src_req_i),
    .clr_we_i   (clr_we_i),
    .clr_mask_i (clr_mask_i),
    .glob_en_i  (glob_en_i),
    .hpmc_i     (hpmc_i),
    .sel_stb_i  (sel_stb_i),
    .ext_irq_o  (ext_irq_o),
    .core_req_o (core_req_o),
    .core_vec_o (core_vec_o),
    .sel_done_o (sel_done_o),
    .sel_hit_o  (sel_hit_o),
    .spur_o     (spur_o),
    .sel_vec_o  (sel_vec_o)
);

// File: tb/test_exirq_dispatch.sv
`timescale 1ns/1ps
module test_exirq_dispatch;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] src_req_i, clr_mask_i, src_en_i, hdl_vld_i;
    logic        clr_we_i, glob_en_i, hpmc_i, tbl_we_i, cnt_we_i, sel_stb_i;
    logic [4:0]  tbl_addr_i, tbl_wdata_i;
    logic [5:0]  cnt_wdata_i;
    logic        ext_irq_o, core_req_o, sel_done_o, sel_hit_o, spur_o;
    logic [4:0]  core_vec_o;
    logic [5:0]  sel_vec_o;

    int total = 0;
    int bad   = 0;
    logic [4:0] tb_tbl [32];
    int         tb_cnt;

    always #2.5 clk = ~clk;

    exirq_dispatch i_exirq_dispatch (.*);

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic raise(input logic [31:0] m);
        src_req_i = m;
        tick();
        src_req_i = '0;
    endtask

    task automatic clear(input logic [31:0] m);
        clr_we_i = 1'b1;
        clr_mask_i = m;
        tick();
        clr_we_i = 1'b0;
        clr_mask_i = '0;
    endtask

    task automatic strobe();
        sel_stb_i = 1'b1;
        tick();
        sel_stb_i = 1'b0;
    endtask

    task automatic wr_tbl(input int a, input int d);
        tbl_we_i = 1'b1;
        tbl_addr_i = 5'(a);
        tbl_wdata_i = 5'(d);
        tick();
        tbl_we_i = 1'b0;
        tb_tbl[a] = 5'(d);
    endtask

    task automatic wr_cnt(input int c);
        cnt_we_i = 1'b1;
        cnt_wdata_i = 6'(c);
        tick();
        cnt_we_i = 1'b0;
        tb_cnt = (c > 32) ? 32 : c;
    endtask

    // Expected {hit, spur, vec} from the requirement text.
    function automatic logic [7:0] model(input logic [31:0] p, input logic [31:0] en,
                                         input logic [31:0] hv, input logic g);
        logic [31:0] el;
        el = p & en & {32{g}};
        if (el == 0) return 8'h00;
        for (int i = 0; i < tb_cnt; i++) begin
            if (el[tb_tbl[i]]) return {1'b1, ~hv[tb_tbl[i]], 6'(32 + int'(tb_tbl[i]))};
        end
        return {1'b0, 1'b1, 6'd0};
    endfunction

    task automatic sel_case(input string req, input logic [31:0] p);
        raise(p);
        strobe();
        chk({req, " done"}, 32'(sel_done_o), 32'd1);
        chk(req, {24'd0, sel_hit_o, spur_o, sel_vec_o},
            {24'd0, model(p, src_en_i, hdl_vld_i, glob_en_i)});
        clear('1);
    endtask

    initial begin
        #(200000 * 5);
        bad++;
        total++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        src_req_i = '0; clr_we_i = 0; clr_mask_i = '0; glob_en_i = 0;
        src_en_i = '1; hdl_vld_i = '1; hpmc_i = 0; tbl_we_i = 0;
        tbl_addr_i = '0; tbl_wdata_i = '0; cnt_we_i = 0; cnt_wdata_i = '0; sel_stb_i = 0;
        for (int i = 0; i < 32; i++) tb_tbl[i] = 5'(i);
        tb_cnt = 32;
        tick(); tick();
        rst_n = 1'b1;
        tick();

        // R9 reset state
        chk("R9 outputs", {26'd0, ext_irq_o, core_req_o, sel_done_o, sel_hit_o, spur_o, 1'b0}, 32'd0);
        chk("R9 vec", 32'(sel_vec_o), 32'd0);
        glob_en_i = 1'b1;
        strobe();
        chk("R9 no pending", {24'd0, sel_hit_o, spur_o, sel_vec_o}, 32'd0);

        // R1 R2 R5 single-source sweep under the reset identity order
        for (int k = 0; k < 32; k++) begin
            raise(32'd1 << k);
            chk("R2 ext_irq", 32'(ext_irq_o), 32'd1);
            chk("R4 core vec ext", 32'(core_vec_o), 32'd4);
            strobe();
            chk("R5 vec", {24'd0, sel_hit_o, spur_o, sel_vec_o}, {24'd0, 2'b10, 6'(32 + k)});
            tick();
            chk("R5 done pulse", 32'(sel_done_o), 32'd0);
            chk("R10 hold", 32'(sel_vec_o), 32'(32 + k));
            clear(32'd1 << k);
            chk("R1 cleared", 32'(ext_irq_o), 32'd0);
        end

        // R1 clear while source still high
        src_req_i = 32'h8;
        tick();
        clear(32'h8);
        src_req_i = '0;
        tick();
        chk("R1 set wins", 32'(ext_irq_o), 32'd1);
        clear(32'h8);
        chk("R1 clear", 32'(ext_irq_o), 32'd0);

        // R2 per-source enable
        src_en_i = ~32'h10;
        raise(32'h10);
        chk("R2 masked", 32'(ext_irq_o), 32'd0);
        strobe();
        chk("R8 masked none", {24'd0, sel_hit_o, spur_o, sel_vec_o}, 32'd0);
        src_en_i = '1;
        tick();
        chk("R2 enabled later", 32'(ext_irq_o), 32'd1);
        clear('1);

        // R3 global enable off; R4 machine check overrides
        glob_en_i = 1'b0;
        raise(32'h0000_0F00);
        chk("R3 ext off", 32'(ext_irq_o), 32'd0);
        chk("R4 idle vec", {26'd0, core_req_o, core_vec_o}, 32'd0);
        strobe();
        chk("R3 sel none", {24'd0, sel_hit_o, spur_o, sel_vec_o}, 32'd0);
        hpmc_i = 1'b1;
        #1;
        chk("R4 hpmc", {26'd0, core_req_o, core_vec_o}, {26'd0, 1'b1, 5'd1});
        glob_en_i = 1'b1;
        #1;
        chk("R4 hpmc priority", 32'(core_vec_o), 32'd1);
        hpmc_i = 1'b0;
        clear('1);

        // R5 R6 reversed order, then count limits, then R7 handler mask
        for (int i = 0; i < 32; i++) wr_tbl(i, 31 - i);
        for (int k = 0; k < 32; k++) sel_case("R6 reversed", (32'd1 << k) | (32'd1 << ((k * 11 + 5) % 32)));
        wr_cnt(16);
        for (int k = 0; k < 32; k++) sel_case("R6 count16", (32'd1 << k) | (32'd1 << ((k * 7 + 3) % 32)));
        hdl_vld_i = 32'h5555_5555;
        for (int k = 0; k < 32; k++) sel_case("R7 handlers", (32'd1 << k) | (32'd1 << ((k * 13 + 9) % 32)));
        sel_case("R7 unlisted", 32'h1);
        wr_cnt(50);
        sel_case("R6 clamp", 32'h1);
        wr_cnt(0);
        sel_case("R7 count0", 32'h8000_0000);
        wr_cnt(32);
        wr_tbl(0, 7); wr_tbl(1, 7); wr_tbl(2, 2);
        sel_case("R5 duplicate", 32'h84);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule